// File: doc/BRIEF.md
# Multiplexed External Data Bus Controller

This block runs external data memory reads and writes for a small 8-bit processor core. The core hands it one request at a time. A request has an address source, a direction, an index byte, a 16-bit pointer and a write byte. The controller then drives a shared bus through two port pin groups. The low group first carries the low address byte, marked by a latch-enable pulse, and then carries the data byte. The high group carries the high address byte. Active-low read and write strobes frame the data phase. When the access finishes, the controller returns the read byte and raises a one-clock completion pulse.

Both port data registers live inside the block. When no access is running, each pin group shows its own register. There are two address sources. A pointer access puts the pointer's upper byte on the high pins for the length of the access and leaves the high register as it was. An index access puts the high register on the high pins, so software can use that register as a page select. Either source can then reach the same 64 KiB space.

Top module: `xdata_bus_ctrl`

## Requirements
- R1: When reset is released, both port registers hold all ones. Both pin groups then show 0xFF, with the low group driven (`lo_oe`=1). `rd_n` and `wr_n` are 1, and `ale`, `done` and `rd_data` are 0.
- R2: When `sfr_wr` is high at a rising edge, the byte is written to a port register: `sfr_sel`=0 selects the low register and `sfr_sel`=1 selects the high register. While idle, each pin group shows its register's new value after the next rising edge.
- R3: A request accepted at edge 0 holds `ale` high for exactly ADDR_CYC cycles, starting right after edge 0. During those cycles `lo_oe` is 1 and the low pins carry the low address byte.
- R4: An index access (`req_ptr`=0) uses `req_idx` as the low address byte. Its high address byte is the high register's value at acceptance. Writing that register during the access does not change the high pins.
- R5: A pointer access (`req_ptr`=1) puts `req_dptr[15:8]` on the high pins and `req_dptr[7:0]` on the low pins. The high register is not changed, and the high pins show it again once `done` is raised.
- R6: A write (`req_write`=1) holds `wr_n` low for STROBE_CYC cycles right after the address phase. The low pins drive `req_wdata` for that whole period and for one more cycle after `wr_n` rises.
- R7: A read (`req_write`=0) holds `rd_n` low for STROBE_CYC cycles right after the address phase. `lo_oe` is 0 during that time. `rd_data` takes the value of `lo_pin_in` at the edge where `rd_n` rises.
- R8: `done` is high for exactly one cycle. For a read it is the cycle right after the strobe. For a write it is the cycle after the hold cycle. `rd_data` is valid in that cycle and keeps its value until the next read.
- R9: A request is accepted only while the controller is idle. A `req_valid` that arrives during an access has no effect: no second address phase follows.
- R10: `rd_n` and `wr_n` are never low in the same cycle. `ale` is never high while a strobe is low. The high pins do not change while a strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request (accepted only when idle) |
| req_ptr | input | 1 | 1 = 16-bit pointer address, 0 = index byte plus page register |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | DATA_W | Index register byte |
| req_dptr | input | 2*DATA_W | Data pointer |
| req_wdata | input | DATA_W | Byte to write |
| sfr_wr | input | 1 | Port register write enable |
| sfr_sel | input | 1 | Port register select: 0 low, 1 high |
| sfr_wdata | input | DATA_W | Port register write value |
| lo_pin_in | input | DATA_W | Low pin group input (read data) |
| lo_pin_out | output | DATA_W | Low pin group output value |
| lo_oe | output | 1 | Low pin group output enable |
| hi_pin_out | output | DATA_W | High pin group output value |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_data | output | DATA_W | Last byte read |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the controller with ADDR_CYC=2 and STROBE_CYC=3 rather than the defaults of 1 and 2. With these values both phase counters must count down through several cycles, which a one-cycle phase would never test. The bench can then check the length of each phase cycle by cycle, and can inject a page-register write and a competing request while the access is still running. DATA_W stays at 8, so the pointer address is 16 bits wide.

// File: rtl/xbc_pkg.sv
package xbc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_HOLD,
    ST_DONE
  } xbc_state_e;

  localparam int NUM_PORTS = 2;
  localparam int PORT_LO   = 0;
  localparam int PORT_HI   = 1;

endpackage

// File: rtl/xbc_port_regs.sv
module xbc_port_regs #(
  parameter int DATA_W    = 8,
  parameter int NUM_PORTS = 2,
  localparam int SEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_en,
  input  logic [SEL_W-1:0]                wr_sel,
  input  logic [DATA_W-1:0]               wr_data,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] reg_q
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [SEL_W-1:0] MY_SEL = SEL_W'(p);

    always_ff @(posedge clk) begin
      if (rst) begin
        reg_q[p] <= '1;
      end else if (wr_en && (wr_sel == MY_SEL)) begin
        reg_q[p] <= wr_data;
      end
    end

    AST_REG_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
      !(wr_en && (wr_sel == MY_SEL)) |=> $stable(reg_q[p])); // R5
  end

endmodule

// File: rtl/xbc_seq.sv
module xbc_seq
  import xbc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_CYC   = 1,
  parameter int STROBE_CYC = 2,
  localparam int ADDR_W    = 2 * DATA_W,
  localparam int MAX_CYC   = (ADDR_CYC > STROBE_CYC) ? ADDR_CYC : STROBE_CYC,
  localparam int CNT_W     = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_ptr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_idx,
  input  logic [ADDR_W-1:0] req_dptr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] page_q,
  output xbc_state_e        state_q,
  output xbc_state_e        state_d,
  output logic [ADDR_W-1:0] addr_d,
  output logic              write_d,
  output logic [DATA_W-1:0] wdata_d
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] addr_q;
  logic              write_q;
  logic [DATA_W-1:0] wdata_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    addr_d  = addr_q;
    write_d = write_q;
    wdata_d = wdata_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_ADDR;
          cnt_d   = CNT_W'(ADDR_CYC - 1);
          addr_d  = req_ptr ? req_dptr : {page_q, req_idx};
          write_d = req_write;
          wdata_d = req_wdata;
        end
      end
      ST_ADDR: begin
        if (cnt_q == '0) begin
          state_d = ST_STRB;
          cnt_d   = CNT_W'(STROBE_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_STRB: begin
        if (cnt_q == '0) begin
          state_d = write_q ? ST_HOLD : ST_DONE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_HOLD: state_d = ST_DONE;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      addr_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      addr_q  <= addr_d;
      write_q <= write_d;
      wdata_q <= wdata_d;
    end
  end

  AST_BUSY_KEEPS_REQUEST: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> ($stable(addr_q) && $stable(write_q) && $stable(wdata_q))); // R9

  AST_HOLD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_HOLD) |-> write_q); // R6

endmodule

// File: rtl/xbc_pin_drv.sv
module xbc_pin_drv
  import xbc_pkg::*;
#(
  parameter int DATA_W  = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  xbc_state_e        state_q,
  input  xbc_state_e        state_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              write_d,
  input  logic [DATA_W-1:0] wdata_d,
  input  logic [DATA_W-1:0] lo_reg,
  input  logic [DATA_W-1:0] hi_reg,
  input  logic [DATA_W-1:0] lo_pin_in,
  output logic [DATA_W-1:0] lo_pin_out,
  output logic              lo_oe,
  output logic [DATA_W-1:0] hi_pin_out,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);

  logic strobe_next;
  logic read_edge;

  assign strobe_next = (state_d == ST_STRB);
  assign read_edge   = (state_q == ST_STRB) && (state_d != ST_STRB) && !write_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_pin_out <= '1;
      lo_oe      <= 1'b1;
      hi_pin_out <= '1;
      ale        <= 1'b0;
      rd_n       <= 1'b1;
      wr_n       <= 1'b1;
      done       <= 1'b0;
      rd_data    <= '0;
    end else begin
      ale  <= (state_d == ST_ADDR);
      rd_n <= !(strobe_next && !write_d);
      wr_n <= !(strobe_next && write_d);
      done <= (state_d == ST_DONE);
      unique case (state_d)
        ST_ADDR: begin
          lo_pin_out <= addr_d[DATA_W-1:0];
          lo_oe      <= 1'b1;
          hi_pin_out <= addr_d[ADDR_W-1:DATA_W];
        end
        ST_STRB, ST_HOLD: begin
          lo_pin_out <= write_d ? wdata_d : addr_d[DATA_W-1:0];
          lo_oe      <= write_d;
          hi_pin_out <= addr_d[ADDR_W-1:DATA_W];
        end
        default: begin
          lo_pin_out <= lo_reg;
          lo_oe      <= 1'b1;
          hi_pin_out <= hi_reg;
        end
      endcase
      if (read_edge) begin
        rd_data <= lo_pin_in;
      end
    end
  end

  AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n)); // R10

  AST_NO_ALE_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    ale |-> (rd_n && wr_n)); // R10

  AST_HI_STEADY_IN_STROBE: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> $stable(hi_pin_out)); // R10

  AST_READ_RELEASES_BUS: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !lo_oe); // R7

  AST_WRITE_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (lo_oe && $stable(lo_pin_out))); // R6

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8

endmodule

// File: rtl/xdata_bus_ctrl.sv
module xdata_bus_ctrl
  import xbc_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int ADDR_CYC   = 1,
  parameter int STROBE_CYC = 2,
  localparam int ADDR_W    = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_ptr,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_idx,
  input  logic [ADDR_W-1:0] req_dptr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              sfr_wr,
  input  logic              sfr_sel,
  input  logic [DATA_W-1:0] sfr_wdata,
  input  logic [DATA_W-1:0] lo_pin_in,
  output logic [DATA_W-1:0] lo_pin_out,
  output logic              lo_oe,
  output logic [DATA_W-1:0] hi_pin_out,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] rd_data,
  output logic              done
);

  logic [NUM_PORTS-1:0][DATA_W-1:0] port_q;
  xbc_state_e                       state_q, state_d;
  logic [ADDR_W-1:0]                addr_d;
  logic                             write_d;
  logic [DATA_W-1:0]                wdata_d;

  xbc_port_regs #(
    .DATA_W    (DATA_W),
    .NUM_PORTS (NUM_PORTS)
  ) u_port_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (sfr_wr),
    .wr_sel  (sfr_sel),
    .wr_data (sfr_wdata),
    .reg_q   (port_q)
  );

  xbc_seq #(
    .DATA_W     (DATA_W),
    .ADDR_CYC   (ADDR_CYC),
    .STROBE_CYC (STROBE_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ptr   (req_ptr),
    .req_write (req_write),
    .req_idx   (req_idx),
    .req_dptr  (req_dptr),
    .req_wdata (req_wdata),
    .page_q    (port_q[PORT_HI]),
    .state_q   (state_q),
    .state_d   (state_d),
    .addr_d    (addr_d),
    .write_d   (write_d),
    .wdata_d   (wdata_d)
  );

  xbc_pin_drv #(
    .DATA_W (DATA_W)
  ) u_pin_drv (
    .clk        (clk),
    .rst        (rst),
    .state_q    (state_q),
    .state_d    (state_d),
    .addr_d     (addr_d),
    .write_d    (write_d),
    .wdata_d    (wdata_d),
    .lo_reg     (port_q[PORT_LO]),
    .hi_reg     (port_q[PORT_HI]),
    .lo_pin_in  (lo_pin_in),
    .lo_pin_out (lo_pin_out),
    .lo_oe      (lo_oe),
    .hi_pin_out (hi_pin_out),
    .ale        (ale),
    .rd_n       (rd_n),
    .wr_n       (wr_n),
    .rd_data    (rd_data),
    .done       (done)
  );

  AST_ONE_REQUEST_IN_FLIGHT: assert property (@(posedge clk) disable iff (rst)
    done |=> !ale); // R9

endmodule

// File: tb/xdata_bus_ctrl_tb.sv
module xdata_bus_ctrl_tb;

  localparam int DW = 8;
  localparam int A  = 2;
  localparam int S  = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ptr = 1'b0;
  logic          req_write = 1'b0;
  logic [DW-1:0] req_idx = '0;
  logic [2*DW-1:0] req_dptr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          sfr_wr = 1'b0;
  logic          sfr_sel = 1'b0;
  logic [DW-1:0] sfr_wdata = '0;
  logic [DW-1:0] lo_pin_in = '0;
  logic [DW-1:0] lo_pin_out;
  logic          lo_oe;
  logic [DW-1:0] hi_pin_out;
  logic          ale, rd_n, wr_n, done;
  logic [DW-1:0] rd_data;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [DW-1:0] lo_reg_m = 8'hFF;
  logic [DW-1:0] hi_reg_m = 8'hFF;

  always #4 clk = ~clk;

  xdata_bus_ctrl #(.DATA_W(DW), .ADDR_CYC(A), .STROBE_CYC(S)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ptr(req_ptr),
    .req_write(req_write), .req_idx(req_idx), .req_dptr(req_dptr),
    .req_wdata(req_wdata), .sfr_wr(sfr_wr), .sfr_sel(sfr_sel),
    .sfr_wdata(sfr_wdata), .lo_pin_in(lo_pin_in), .lo_pin_out(lo_pin_out),
    .lo_oe(lo_oe), .hi_pin_out(hi_pin_out), .ale(ale), .rd_n(rd_n),
    .wr_n(wr_n), .rd_data(rd_data), .done(done)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sfr_write(input logic sel, input logic [DW-1:0] val);
    @(negedge clk);
    sfr_wr = 1'b1; sfr_sel = sel; sfr_wdata = val;
    @(negedge clk);
    sfr_wr = 1'b0;
    if (sel) hi_reg_m = val; else lo_reg_m = val;
  endtask

  // Runs one access; checks every cycle against the phase schedule.
  task automatic run_access(input logic ptr, input logic wr, input logic [7:0] idx,
                            input logic [15:0] dptr, input logic [7:0] wdata,
                            input logic [7:0] rdval, input bit poke_page,
                            input bit poke_req, input string name);
    logic [7:0] exp_hi, exp_lo;
    int done_k;
    exp_hi = ptr ? dptr[15:8] : hi_reg_m;
    exp_lo = ptr ? dptr[7:0] : idx;
    done_k = wr ? A + S + 1 : A + S;
    @(negedge clk);
    req_valid = 1'b1; req_ptr = ptr; req_write = wr; req_idx = idx;
    req_dptr = dptr; req_wdata = wdata; lo_pin_in = rdval;
    for (int k = 0; k <= done_k + 3; k++) begin
      @(negedge clk);
      if (k == 0) req_valid = 1'b0;
      if (k < A) begin
        chk({name, " R3 ale"}, 16'(ale), 16'd1);
        chk({name, " R3 lo addr"}, 16'(lo_pin_out), 16'(exp_lo));
        chk({name, " R3 lo_oe"}, 16'(lo_oe), 16'd1);
      end else begin
        chk({name, " R3/R9 ale low"}, 16'(ale), 16'd0);
      end
      if (k < done_k) begin
        chk({name, ptr ? " R5 hi addr" : " R4 hi page"}, 16'(hi_pin_out), 16'(exp_hi));
      end
      if (k >= A && k < A + S) begin
        if (wr) begin
          chk({name, " R6 wr_n low"}, 16'(wr_n), 16'd0);
          chk({name, " R6 wdata"}, 16'(lo_pin_out), 16'(wdata));
          chk({name, " R6 oe"}, 16'(lo_oe), 16'd1);
          chk({name, " R10 rd_n idle"}, 16'(rd_n), 16'd1);
        end else begin
          chk({name, " R7 rd_n low"}, 16'(rd_n), 16'd0);
          chk({name, " R7 released"}, 16'(lo_oe), 16'd0);
          chk({name, " R10 wr_n idle"}, 16'(wr_n), 16'd1);
        end
      end else begin
        chk({name, " R6/R7 strobes high"}, 16'({rd_n, wr_n}), 16'h3);
      end
      if (wr && k == A + S) begin
        chk({name, " R6 hold data"}, 16'(lo_pin_out), 16'(wdata));
        chk({name, " R6 hold oe"}, 16'(lo_oe), 16'd1);
      end
      chk({name, " R8 done"}, 16'(done), (k == done_k) ? 16'd1 : 16'd0);
      if (!wr && k == done_k) chk({name, " R7/R8 rd_data"}, 16'(rd_data), 16'(rdval));
      if (k >= done_k) begin
        chk({name, " R5/R2 hi idle"}, 16'(hi_pin_out), 16'(hi_reg_m));
        chk({name, " R2 lo idle"}, 16'(lo_pin_out), 16'(lo_reg_m));
      end
      if (k == 1 && poke_page) begin
        sfr_wr = 1'b1; sfr_sel = 1'b1; sfr_wdata = 8'h77;
      end
      if (k == 2 && poke_page) begin
        sfr_wr = 1'b0; hi_reg_m = 8'h77;
      end
      if (k == 1 && poke_req) begin
        req_valid = 1'b1; req_ptr = 1'b1; req_write = 1'b1; req_dptr = 16'hBEEF;
      end
      if (k == done_k - 1 && poke_req) req_valid = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R1 lo pins", 16'(lo_pin_out), 16'hFF);
    chk("R1 hi pins", 16'(hi_pin_out), 16'hFF);
    chk("R1 lo_oe", 16'(lo_oe), 16'd1);
    chk("R1 strobes", 16'({rd_n, wr_n}), 16'h3);
    chk("R1 ale", 16'(ale), 16'd0);
    chk("R1 done", 16'(done), 16'd0);
    chk("R1 rd_data", 16'(rd_data), 16'd0);
  endtask

  task automatic t_sfr_idle();
    sfr_write(1'b0, 8'h5A);
    sfr_write(1'b1, 8'h3C);
    @(negedge clk);
    chk("R2 lo reg on pins", 16'(lo_pin_out), 16'h5A);
    chk("R2 hi reg on pins", 16'(hi_pin_out), 16'h3C);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sfr_idle();
    run_access(1'b0, 1'b1, 8'h21, 16'h0000, 8'hA5, 8'h00, 1'b0, 1'b0, "idx write R4");
    run_access(1'b1, 1'b0, 8'h00, 16'h9C4E, 8'h00, 8'hD3, 1'b0, 1'b0, "ptr read R5");
    run_access(1'b1, 1'b1, 8'h00, 16'hFF01, 8'h5F, 8'h00, 1'b0, 1'b0, "ptr write R5");
    run_access(1'b0, 1'b0, 8'hE0, 16'h0000, 8'h00, 8'h6B, 1'b1, 1'b0, "idx read page poke R4");
    chk("R4 page register kept new value", 16'(hi_pin_out), 16'h77);
    run_access(1'b0, 1'b1, 8'h10, 16'h0000, 8'hC3, 8'h00, 1'b0, 1'b1, "busy ignore R9");
    run_access(1'b1, 1'b0, 8'h00, 16'h1234, 8'h00, 8'h00, 1'b0, 1'b0, "zero read R7");
    chk("R8 rd_data kept after done", 16'(rd_data), 16'h00);
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule